// File: doc/BRIEF.md
# Buffered Prescaled Timebase Counter

This block is a time base: an up-counter advanced by a programmable clock divider. It counts from zero up to a reload limit and wraps back to zero, which marks an overflow. An overflow, or a software update pulse, forms an update event. The update event copies buffered settings into the active registers, sets a sticky update flag, and can raise an interrupt level or a DMA request pulse.

The divide ratio is always buffered and only takes effect at an update event. Buffering of the reload limit is selectable. Update events can be suppressed altogether. Software-forced updates can also be made silent, so that they do not set the flag. A one-pulse option clears the enable after one update. A trigger output, chosen by a 3-bit selector, lets a neighbouring converter or timer follow the software update pulse, the running state or the update event.

All settings arrive as plain levels or one-cycle write strobes from surrounding register logic. Everything runs on a single clock.

Top module: `tbase_timer`

## Requirements
- R1: A tick happens once every P+1 running cycles, where P is the active divide value (16 bits, ratio 1 to 65536). A write to the divide value changes `psc_active` only at the next update event, including one forced by `sw_update`.
- R2: On each tick the counter advances by one. On a tick with the count at or above the active reload value L, the count goes to 0 and this is an overflow. While L is 0 the counter does not move and no overflow occurs.
- R3: With `arpe` low, a reload write changes `rld_active` on the next clock. With `arpe` high, the write is held aside and copied into `rld_active` at the next update event.
- R4: With `udis` high, no update event is formed: `psc_active` and `rld_active` keep their values and the flag is not set. A `sw_update` still clears the counter and the divider count to 0.
- R5: With `urs` high, a `sw_update` still loads the buffered values, but it does not set the flag and does not request DMA. Overflows still set the flag.
- R6: With `opm` high, `en_bit` is cleared by the clock edge of the next update event. Counting stops one cycle later.
- R7: `en_bit` follows a write through `en_wr` on the next clock. The internal running state follows `en_bit` one clock later, and counting starts from then.
- R8: `trig_out` is combinational on the selector `mm_sel`: 000 gives the `sw_update` input, 001 gives the internal running state, 010 gives the update event, and every other code gives 0.
- R9: The flag is set by a flag-setting update event and cleared by a `flag_clr` pulse. A set wins over a clear in the same cycle. `cnt_rd[31]` equals the flag when `remap` is high and is 0 otherwise. `cnt_rd[15:0]` is the count.
- R10: `irq` is the flag AND `irq_en`. `dma_req` pulses high for exactly one cycle, together with the flag's setting edge, for each flag-setting update while `dma_en` is high.
- R11: After reset, the count is 0, `psc_active` is 0, `rld_active` is 0xFFFF, and the flag, `en_bit`, `irq`, `dma_req` and `trig_out` (selector 000, no pulse) are 0.
- R12: `cnt_wr` loads the count directly on the next clock. A `sw_update` takes priority over it and clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Strobe: write `en_wdata` into the enable bit |
| en_wdata | input | 1 | Enable value to write |
| arpe | input | 1 | Reload buffering select |
| udis | input | 1 | Suppress update events |
| urs | input | 1 | Software updates leave the flag alone |
| opm | input | 1 | One-pulse mode |
| sw_update | input | 1 | Software update pulse |
| psc_wr | input | 1 | Strobe: write buffered divide value |
| psc_wdata | input | 16 | Divide value (ratio minus one) |
| rld_wr | input | 1 | Strobe: write reload value |
| rld_wdata | input | 16 | Reload value |
| cnt_wr | input | 1 | Strobe: write counter |
| cnt_wdata | input | 16 | Counter value |
| flag_clr | input | 1 | Clear the update flag |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA request enable |
| remap | input | 1 | Copy the flag into bit 31 of `cnt_rd` |
| mm_sel | input | 3 | Trigger source selector |
| en_bit | output | 1 | Enable bit readback |
| cnt_rd | output | 32 | Counter readback with flag copy in bit 31 |
| rld_active | output | 16 | Active reload value |
| psc_active | output | 16 | Active divide value |
| flag | output | 1 | Sticky update flag |
| irq | output | 1 | Interrupt level |
| dma_req | output | 1 | One-cycle DMA request |
| trig_out | output | 1 | Selected trigger |

## Verification
The hardest case to reach from the ports is the one-pulse stop. `en_bit` drops on the overflow edge, but the running state lags by one cycle, so the counter takes one more step past zero before it halts. The stimulus sets the limit to 3, enables counting and steps exactly to the overflow edge. It then checks the count over the following cycles, with every register between the enable write and the counter included in the count. Buffered reload and divide changes are reached in a similar way: new values are written in the middle of a counting period, the old active values are confirmed, and then the clock is run to the overflow or a software update is forced.

// File: rtl/tbase_pkg.sv
`timescale 1ns/1ps
package tbase_pkg;
  localparam logic [2:0] MM_SWUPD  = 3'b000;
  localparam logic [2:0] MM_RUN    = 3'b001;
  localparam logic [2:0] MM_UPDATE = 3'b010;

  // wrap condition: value has reached or passed the limit
  function automatic logic reached_top(input logic [31:0] value, input logic [31:0] top);
    return value >= top;
  endfunction

  // divider restarts on the tick, otherwise climbs while running
  function automatic logic [31:0] next_div(input logic [31:0] cur, input logic at_end);
    return at_end ? 32'd0 : cur + 32'd1;
  endfunction
endpackage

// File: rtl/tbase_prescaler.sv
`timescale 1ns/1ps
module tbase_prescaler
  import tbase_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic          load,
  input  logic [PW-1:0] psc_pre,
  output logic          tick,
  output logic [PW-1:0] psc_active
);
  logic [PW-1:0] div_q;
  logic [PW-1:0] act_q;

  assign tick       = run && (div_q == act_q);
  assign psc_active = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      act_q <= '0;
    end else begin
      if (load) act_q <= psc_pre;
      if (restart)  div_q <= '0;
      else if (run) div_q <= PW'(next_div(32'(div_q), tick));
    end
  end

  // R1: divider count frozen while stopped and not restarted
  a_r1_div_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(div_q));
endmodule

// File: rtl/tbase_counter.sv
`timescale 1ns/1ps
module tbase_counter
  import tbase_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          rld_wr,
  input  logic [CW-1:0] rld_wdata,
  input  logic          arpe,
  input  logic          load,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] rld_active,
  output logic          ovf
);
  localparam logic [CW-1:0] RLD_RESET = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] pre_q;
  logic [CW-1:0] act_q;
  logic          limit_zero;

  assign limit_zero = (act_q == '0);
  assign ovf        = tick && !limit_zero && reached_top(32'(cnt_q), 32'(act_q));
  assign cnt        = cnt_q;
  assign rld_active = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= RLD_RESET;
      act_q <= RLD_RESET;
    end else begin
      if (restart)                  cnt_q <= '0;
      else if (cnt_wr)              cnt_q <= cnt_wdata;
      else if (ovf)                 cnt_q <= '0;
      else if (tick && !limit_zero) cnt_q <= cnt_q + 1'b1;

      if (rld_wr) pre_q <= rld_wdata;
      if (rld_wr && !arpe) act_q <= rld_wdata;
      else if (load)       act_q <= pre_q;
    end
  end

  // R2: a zero limit blocks the counter
  a_r2_hold_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_zero && !restart && !cnt_wr) |=> $stable(cnt_q));
  // R12: software update always clears the count
  a_r12_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/tbase_events.sv
`timescale 1ns/1ps
module tbase_events
  import tbase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uev,
  input  logic       ovf,
  input  logic       sw_update,
  input  logic       urs,
  input  logic       flag_clr,
  input  logic       irq_en,
  input  logic       dma_en,
  input  logic       cnt_run,
  input  logic [2:0] mm_sel,
  output logic       flag,
  output logic       irq,
  output logic       dma_req,
  output logic       trig_out
);
  logic flag_set;
  logic flag_q;
  logic dma_q;

  assign flag_set = uev && (ovf || (sw_update && !urs));
  assign flag     = flag_q;
  assign irq      = flag_q & irq_en;
  assign dma_req  = dma_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      if (flag_set)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      dma_q <= flag_set && dma_en;
    end
  end

  always_comb begin
    case (mm_sel)
      MM_SWUPD:  trig_out = sw_update;
      MM_RUN:    trig_out = cnt_run;
      MM_UPDATE: trig_out = uev;
      default:   trig_out = 1'b0;
    endcase
  end

  // R10: a DMA pulse always coincides with a set flag
  a_r10_dma_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |-> flag_q);
  // R5: a silent software update never raises the flag
  a_r5_silent_sw: assert property (@(posedge clk) disable iff (!rst_n)
    (urs && sw_update && !ovf && !flag_q) |=> !flag_q);
endmodule

// File: rtl/tbase_timer.sv
`timescale 1ns/1ps
module tbase_timer
  import tbase_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PW  = 16,
  parameter int RDW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_wr,
  input  logic           en_wdata,
  input  logic           arpe,
  input  logic           udis,
  input  logic           urs,
  input  logic           opm,
  input  logic           sw_update,
  input  logic           psc_wr,
  input  logic [PW-1:0]  psc_wdata,
  input  logic           rld_wr,
  input  logic [CW-1:0]  rld_wdata,
  input  logic           cnt_wr,
  input  logic [CW-1:0]  cnt_wdata,
  input  logic           flag_clr,
  input  logic           irq_en,
  input  logic           dma_en,
  input  logic           remap,
  input  logic [2:0]     mm_sel,
  output logic           en_bit,
  output logic [RDW-1:0] cnt_rd,
  output logic [CW-1:0]  rld_active,
  output logic [PW-1:0]  psc_active,
  output logic           flag,
  output logic           irq,
  output logic           dma_req,
  output logic           trig_out
);
  localparam int PADW = RDW - 1 - CW;

  logic          en_q;
  logic          run_q;
  logic          tick;
  logic          ovf;
  logic          uev;
  logic [PW-1:0] psc_pre_q;
  logic [CW-1:0] cnt;

  assign uev    = !udis && (ovf || sw_update);
  assign en_bit = en_q;
  assign cnt_rd = {remap & flag, {PADW{1'b0}}, cnt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      run_q     <= 1'b0;
      psc_pre_q <= '0;
    end else begin
      if (en_wr)            en_q <= en_wdata;
      else if (opm && uev)  en_q <= 1'b0;
      run_q <= en_q;
      if (psc_wr) psc_pre_q <= psc_wdata;
    end
  end

  tbase_prescaler #(.PW(PW)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .restart(sw_update), .load(uev),
    .psc_pre(psc_pre_q), .tick(tick), .psc_active(psc_active)
  );

  tbase_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(sw_update),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .rld_wr(rld_wr), .rld_wdata(rld_wdata),
    .arpe(arpe), .load(uev), .cnt(cnt), .rld_active(rld_active), .ovf(ovf)
  );

  tbase_events u_evt (
    .clk(clk), .rst_n(rst_n), .uev(uev), .ovf(ovf), .sw_update(sw_update),
    .urs(urs), .flag_clr(flag_clr), .irq_en(irq_en), .dma_en(dma_en),
    .cnt_run(run_q), .mm_sel(mm_sel), .flag(flag), .irq(irq),
    .dma_req(dma_req), .trig_out(trig_out)
  );

  // R6: one-pulse mode drops the enable at the update edge
  a_r6_opm_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (opm && uev && !en_wr) |=> !en_q);
  // R4: active divide value untouched while updates are disabled
  a_r4_psc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    udis |=> $stable(psc_active));
  // R7: running state follows an enable write after two edges
  a_r7_run_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && en_wdata) |=> ##1 run_q);
endmodule

// File: tb/tbase_timer_test.sv
`timescale 1ns/1ps
module tbase_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_wr, en_wdata, arpe, udis, urs, opm, sw_update;
  logic        psc_wr, rld_wr, cnt_wr, flag_clr, irq_en, dma_en, remap;
  logic [15:0] psc_wdata, rld_wdata, cnt_wdata;
  logic [2:0]  mm_sel;
  logic        en_bit, flag, irq, dma_req, trig_out;
  logic [31:0] cnt_rd;
  logic [15:0] rld_active, psc_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tbase_timer uut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata), .arpe(arpe),
    .udis(udis), .urs(urs), .opm(opm), .sw_update(sw_update),
    .psc_wr(psc_wr), .psc_wdata(psc_wdata), .rld_wr(rld_wr), .rld_wdata(rld_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .flag_clr(flag_clr), .irq_en(irq_en),
    .dma_en(dma_en), .remap(remap), .mm_sel(mm_sel), .en_bit(en_bit),
    .cnt_rd(cnt_rd), .rld_active(rld_active), .psc_active(psc_active),
    .flag(flag), .irq(irq), .dma_req(dma_req), .trig_out(trig_out)
  );

  // rows: {divide value P, reload L, running cycles N}
  localparam logic [47:0] VEC [0:7] = '{
    {16'd0, 16'd5,      16'd4},
    {16'd0, 16'd5,      16'd6},
    {16'd0, 16'd5,      16'd13},
    {16'd1, 16'd3,      16'd9},
    {16'd3, 16'd7,      16'd20},
    {16'd2, 16'd0,      16'd9},
    {16'd4, 16'd2,      16'd31},
    {16'd0, 16'hFFFF,   16'd50}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobes_off();
    en_wr = 0; en_wdata = 0; sw_update = 0; psc_wr = 0; rld_wr = 0;
    cnt_wr = 0; flag_clr = 0;
  endtask

  task automatic do_reset();
    strobes_off();
    arpe = 0; udis = 0; urs = 0; opm = 0; irq_en = 0; dma_en = 0; remap = 0;
    mm_sel = 3'b000; psc_wdata = 0; rld_wdata = 0; cnt_wdata = 0;
    rst_n = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  // loads P and L, forces an update, clears the flag and writes enable=1;
  // returns just after the edge that sets the enable bit
  task automatic setup(input logic [15:0] p, input logic [15:0] l);
    psc_wr = 1; psc_wdata = p; rld_wr = 1; rld_wdata = l;
    step(1); strobes_off();
    sw_update = 1;
    step(1); strobes_off();
    flag_clr = 1; en_wr = 1; en_wdata = 1;
    step(1); strobes_off();
  endtask

  function automatic logic [31:0] exp_cnt(input int p, input int l, input int n);
    int ticks = n / (p + 1);
    if (l == 0) return 0;
    return ticks % (l + 1);
  endfunction

  initial begin
    rst_n = 0;
    do_reset();

    // R11 reset state
    chk("R11 count", cnt_rd, 0);
    chk("R11 psc_active", psc_active, 0);
    chk("R11 rld_active", rld_active, 16'hFFFF);
    chk("R11 flag", flag, 0);
    chk("R11 en_bit", en_bit, 0);
    chk("R11 irq", irq, 0);
    chk("R11 dma", dma_req, 0);
    chk("R11 trig", trig_out, 0);

    // vector table: R1 divide, R2 count and wrap
    for (int i = 0; i < 8; i++) begin
      int p, l, n;
      p = int'(VEC[i][47:32]); l = int'(VEC[i][31:16]); n = int'(VEC[i][15:0]);
      do_reset();
      setup(16'(p), 16'(l));
      step(1 + n);
      chk($sformatf("R1 R2 row %0d count", i), {16'h0, cnt_rd[15:0]}, exp_cnt(p, l, n));
      chk($sformatf("R2 row %0d flag", i), flag,
          (l != 0 && (n / (p + 1)) > l) ? 1 : 0);
    end

    // R7 enable lag, seen on trigger select 001 (R8)
    do_reset();
    mm_sel = 3'b001;
    setup(16'd0, 16'd100);
    chk("R7 en_bit set", en_bit, 1);
    chk("R7 run not yet", trig_out, 0);
    step(1);
    chk("R8 run on trig", trig_out, 1);
    step(3);
    chk("R7 counting", cnt_rd, 3);

    // R1 buffered divide value
    psc_wr = 1; psc_wdata = 16'd3;
    step(1); strobes_off();
    chk("R1 psc held", psc_active, 0);
    step(2);
    chk("R1 old ratio", cnt_rd, 6);
    sw_update = 1;
    step(1); strobes_off();
    chk("R12 sw clears", cnt_rd[15:0], 0);
    chk("R1 psc loaded", psc_active, 3);
    step(8);
    chk("R1 new ratio", cnt_rd[15:0], 2);

    // R3 buffered reload
    do_reset();
    setup(16'd0, 16'd5);
    arpe = 1; rld_wr = 1; rld_wdata = 16'd2;
    step(1); strobes_off();
    chk("R3 reload held", rld_active, 5);
    step(5);
    chk("R3 count at limit", cnt_rd[15:0], 5);
    chk("R3 still held", rld_active, 5);
    step(1);
    chk("R3 wrapped", cnt_rd[15:0], 0);
    chk("R3 loaded at update", rld_active, 2);
    step(3);
    chk("R3 new limit used", cnt_rd[15:0], 0);
    arpe = 0; rld_wr = 1; rld_wdata = 16'd9;
    step(1); strobes_off();
    chk("R3 direct write", rld_active, 9);

    // R4 update disable, R12 counter write
    do_reset();
    udis = 1; mm_sel = 3'b010;
    psc_wr = 1; psc_wdata = 16'd7; cnt_wr = 1; cnt_wdata = 16'd50;
    step(1); strobes_off();
    chk("R12 counter write", cnt_rd, 50);
    sw_update = 1;
    #1 chk("R8 no update pulse when disabled", trig_out, 0);
    step(1); strobes_off();
    chk("R4 count cleared", cnt_rd, 0);
    chk("R4 psc kept", psc_active, 0);
    chk("R4 no flag", flag, 0);
    rld_wr = 1; rld_wdata = 16'd2; en_wr = 1; en_wdata = 1;
    step(1); strobes_off();
    step(12);
    chk("R4 overflow no flag", flag, 0);

    // R5 silent software update
    do_reset();
    urs = 1;
    psc_wr = 1; psc_wdata = 16'd2;
    step(1); strobes_off();
    sw_update = 1;
    step(1); strobes_off();
    chk("R5 psc loaded", psc_active, 2);
    chk("R5 no flag", flag, 0);
    rld_wr = 1; rld_wdata = 16'd1; en_wr = 1; en_wdata = 1;
    step(1); strobes_off();
    step(20);
    chk("R5 overflow sets flag", flag, 1);

    // R6 one-pulse mode
    do_reset();
    opm = 1;
    setup(16'd0, 16'd3);
    step(4);
    chk("R6 before update", {en_bit, 15'h0, cnt_rd[15:0]}, {1'b1, 15'h0, 16'd3});
    step(1);
    chk("R6 enable dropped", en_bit, 0);
    chk("R6 wrapped", cnt_rd[15:0], 0);
    step(4);
    chk("R6 one lag step then stop", cnt_rd[15:0], 1);

    // R9 flag copy and clear, R10 irq
    remap = 1; irq_en = 1;
    #1 chk("R9 bit31 copy", cnt_rd[31], 1);
    chk("R10 irq level", irq, 1);
    remap = 0;
    #1 chk("R9 bit31 off", cnt_rd[31], 0);
    flag_clr = 1;
    step(1); strobes_off();
    chk("R9 flag cleared", flag, 0);
    chk("R10 irq low", irq, 0);

    // R10 DMA pulse, R8 trigger selects
    do_reset();
    dma_en = 1; mm_sel = 3'b000;
    sw_update = 1;
    #1 chk("R8 sw strobe on trig", trig_out, 1);
    step(1); strobes_off();
    chk("R10 dma pulse", dma_req, 1);
    chk("R9 flag set", flag, 1);
    step(1);
    chk("R10 dma one cycle", dma_req, 0);
    mm_sel = 3'b011; sw_update = 1;
    #1 chk("R8 unused code low", trig_out, 0);
    mm_sel = 3'b010;
    #1 chk("R8 update on trig", trig_out, 1);
    step(1); strobes_off();
    urs = 1; sw_update = 1;
    step(1); strobes_off();
    step(1);
    chk("R10 no dma for silent update", dma_req, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule